// File: doc/BRIEF.md
# Meta-Gated Transmit Packet Framer

This block sits on the transmit path between user logic and a network stack. Each transmission consists of one 64-bit metadata word (destination and source node rank and port, plus a byte length) and one 64-bit data packet. Both travel on valid/ready streams. The framer does not take any data beat until it has accepted a metadata word. It always hands the downstream side a metadata word that carries the true byte length, and a data packet whose final beat carries tlast.

The block has two framing modes, chosen by the length field of the incoming metadata.

- **Length mode (nonzero length).** The byte count ends the packet and any tlast on the input is ignored. The framer forwards the metadata at once. It closes the packet itself: it shapes the tkeep of the final beat and raises tlast on it.
- **Tlast mode (zero length).** The incoming tlast ends the packet. The framer stores the beats in an internal buffer and adds up the valid bytes. Only when the tlast beat arrives does it release the metadata, with the computed length, followed by the stored beats.

Back-pressure rules:
- Every stream obeys the usual rule: once valid is high, the payload stays stable until ready is seen.
- Only one packet is in flight at a time. The metadata input is not ready again until the final output beat has been accepted.
- The data input stalls whenever the buffer is full.
- The data output stalls until the outgoing metadata has been accepted.

Top module: `tpf_tx_framer`

## Requirements
- R1: `meta_in_ready` is high only while no packet is in flight. It falls on the cycle after a metadata handshake and rises again on the cycle after the output beat with tlast is accepted.
- R2: `din_ready` stays low while no metadata word is held. A data beat offered before the metadata is held, and it is taken only after the metadata handshake.
- R3: The metadata layout is fixed and is the same on the input and the output. Bits [7:0] hold the destination rank, [23:8] the destination port, [31:24] the source rank, [47:32] the source port and [63:48] the byte length. The framer copies the rank and port fields unchanged.
- R4: In length mode, `meta_out_valid` is high in the cycle after the metadata handshake, and the length field is unchanged. The packet is ceil(len/8) beats long, and no further input beat is taken after the last of them.
- R5: In length mode, every non-final output beat has tkeep 8'hFF. The final beat has tkeep set to the low (len mod 8) bits, or 8'hFF when that remainder is 0. Tlast is raised on the final beat only, and an incoming tlast on an earlier beat has no effect.
- R6: In tlast mode, `meta_out_valid` stays low until the input beat carrying tlast is accepted. It then rises, with length = sum of popcount(tkeep) over all beats. Each beat's tkeep passes unchanged, and tlast marks the same beat that carried it on the input.
- R7: In tlast mode, a packet that reaches DEPTH beats without tlast is cut off. Beat DEPTH becomes the final beat with tlast, and no further beat is taken.
- R8: No output data beat is offered before the outgoing metadata has been accepted.
- R9: While valid is high and ready is low, an output keeps valid high and its payload stable. Data beats leave in arrival order with tdata unchanged.
- R10: After reset: `meta_in_ready`=1, `din_ready`=0, `meta_out_valid`=0, `dout_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meta_in_tdata | input | 64 | Incoming metadata word |
| meta_in_valid | input | 1 | Incoming metadata valid |
| meta_in_ready | output | 1 | Framer can accept metadata |
| din_tdata | input | 64 | Incoming payload beat |
| din_tkeep | input | 8 | Byte enables of incoming beat |
| din_tlast | input | 1 | End marker (used in tlast mode only) |
| din_valid | input | 1 | Incoming beat valid |
| din_ready | output | 1 | Framer takes incoming beat |
| meta_out_tdata | output | 64 | Outgoing metadata with final length |
| meta_out_valid | output | 1 | Outgoing metadata valid |
| meta_out_ready | input | 1 | Downstream takes metadata |
| dout_tdata | output | 64 | Outgoing payload beat |
| dout_tkeep | output | 8 | Byte enables of outgoing beat |
| dout_tlast | output | 1 | Final beat of packet |
| dout_valid | output | 1 | Outgoing beat valid |
| dout_ready | input | 1 | Downstream takes beat |

## Verification
A wrong remaining-byte counter or a wrong running sum appears at the ports within the packet it corrupts. It shows either as a final tkeep or tlast on the wrong beat, or as an outgoing length that differs from the bytes actually delivered. A wrong in-flight or metadata-sent flag shows up within a cycle or two, in one of three ways: a data beat taken before any metadata, a data beat offered ahead of the metadata, or a second metadata accepted mid-packet. The bench sweeps every length from 1 to 40 plus the full-buffer length, and tlast packets of one to eight beats, with and without alternating back-pressure. This exposes every remainder class and every beat count at the ports.

// File: rtl/tpf_pkg.sv
package tpf_pkg;
  localparam int META_W = 64;
  localparam int LEN_W  = 16;

  // Metadata word, packed MSB first: len sits at [63:48], dst_rank at [7:0]
  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [15:0]      src_port;
    logic [7:0]       src_rank;
    logic [15:0]      dst_port;
    logic [7:0]       dst_rank;
  } meta_t;
endpackage

// File: rtl/tpf_beat_fifo.sv
module tpf_beat_fifo #(
  parameter int WIDTH = 73,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_en) wptr <= bump(wptr);
      if (rd_en) rptr <= bump(rptr);
      case ({wr_en, rd_en})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/tpf_beat_shaper.sv
module tpf_beat_shaper #(
  parameter int KEEP_W = 8,
  parameter int LEN_W  = 16
) (
  input  logic              len_mode,
  input  logic [LEN_W-1:0]  rem_bytes,
  input  logic [KEEP_W-1:0] in_keep,
  input  logic              in_last,
  input  logic              last_slot,
  output logic              final_o,
  output logic [KEEP_W-1:0] keep_o,
  output logic [LEN_W-1:0]  bytes_o
);
  logic [KEEP_W-1:0] tail_mask;
  logic              len_final;

  // byte i of the closing beat survives while i < remaining bytes
  for (genvar i = 0; i < KEEP_W; i++) begin : g_mask
    assign tail_mask[i] = (rem_bytes > LEN_W'(i));
  end

  assign len_final = (rem_bytes <= LEN_W'(KEEP_W));

  always_comb begin
    bytes_o = '0;
    for (int i = 0; i < KEEP_W; i++) bytes_o = bytes_o + LEN_W'(in_keep[i]);
  end

  assign final_o = len_mode ? len_final : (in_last | last_slot);
  assign keep_o  = len_mode ? (len_final ? tail_mask : '1) : in_keep;
endmodule

// File: rtl/tpf_frame_ctrl.sv
module tpf_frame_ctrl
  import tpf_pkg::*;
#(
  parameter int KEEP_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [META_W-1:0]  mi_tdata,
  input  logic               mi_valid,
  output logic               mi_ready,
  input  logic               din_valid,
  output logic               din_ready,
  input  logic               fifo_full,
  input  logic               beat_final,
  input  logic [LEN_W-1:0]   beat_bytes,
  output logic               wr_en,
  output logic               len_mode,
  output logic [LEN_W-1:0]   rem_bytes,
  output logic [META_W-1:0]  mo_tdata,
  output logic               mo_valid,
  input  logic               mo_ready,
  input  logic               rd_fire,
  input  logic               rd_last,
  output logic               drain_en
);
  logic             busy, in_done, sent;
  logic [LEN_W-1:0] sum_q;
  meta_t            meta_q;
  meta_t            mi_meta;

  assign mi_meta   = meta_t'(mi_tdata);
  assign mi_ready  = !busy;
  assign din_ready = busy && !in_done && !fifo_full;
  assign wr_en     = din_valid && din_ready;
  assign mo_tdata  = META_W'(meta_q);
  assign drain_en  = sent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      in_done   <= 1'b0;
      sent      <= 1'b0;
      len_mode  <= 1'b0;
      rem_bytes <= '0;
      sum_q     <= '0;
      meta_q    <= '0;
      mo_valid  <= 1'b0;
    end else begin
      if (mi_valid && mi_ready) begin
        busy      <= 1'b1;
        in_done   <= 1'b0;
        sent      <= 1'b0;
        len_mode  <= (mi_meta.len != '0);
        rem_bytes <= mi_meta.len;
        sum_q     <= '0;
        meta_q    <= mi_meta;
        mo_valid  <= (mi_meta.len != '0);
      end
      if (wr_en) begin
        if (len_mode) rem_bytes <= rem_bytes - LEN_W'(KEEP_W);
        else          sum_q     <= sum_q + beat_bytes;
        if (beat_final) begin
          in_done <= 1'b1;
          if (!len_mode) begin
            meta_q.len <= sum_q + beat_bytes;
            mo_valid   <= 1'b1;
          end
        end
      end
      if (mo_valid && mo_ready) begin
        mo_valid <= 1'b0;
        sent     <= 1'b1;
      end
      if (rd_fire && rd_last) begin
        busy <= 1'b0;
        sent <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tpf_tx_framer.sv
module tpf_tx_framer
  import tpf_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [META_W-1:0]   meta_in_tdata,
  input  logic                meta_in_valid,
  output logic                meta_in_ready,
  input  logic [DATA_W-1:0]   din_tdata,
  input  logic [DATA_W/8-1:0] din_tkeep,
  input  logic                din_tlast,
  input  logic                din_valid,
  output logic                din_ready,
  output logic [META_W-1:0]   meta_out_tdata,
  output logic                meta_out_valid,
  input  logic                meta_out_ready,
  output logic [DATA_W-1:0]   dout_tdata,
  output logic [DATA_W/8-1:0] dout_tkeep,
  output logic                dout_tlast,
  output logic                dout_valid,
  input  logic                dout_ready
);
  localparam int KEEP_W  = DATA_W / 8;
  localparam int ENTRY_W = DATA_W + KEEP_W + 1;
  localparam int CW      = $clog2(DEPTH + 1);

  logic               wr_en, rd_en, fifo_full, fifo_empty, drain_en;
  logic               len_mode, beat_final, last_slot;
  logic [LEN_W-1:0]   rem_bytes, beat_bytes;
  logic [KEEP_W-1:0]  keep_sh;
  logic [CW-1:0]      fifo_count;
  logic [ENTRY_W-1:0] wr_entry, rd_entry;

  assign last_slot = (fifo_count == CW'(DEPTH - 1));
  assign wr_entry  = {beat_final, keep_sh, din_tdata};

  tpf_beat_shaper #(.KEEP_W(KEEP_W), .LEN_W(LEN_W)) shaper_i (
    .len_mode  (len_mode),
    .rem_bytes (rem_bytes),
    .in_keep   (din_tkeep),
    .in_last   (din_tlast),
    .last_slot (last_slot),
    .final_o   (beat_final),
    .keep_o    (keep_sh),
    .bytes_o   (beat_bytes)
  );

  tpf_frame_ctrl #(.KEEP_W(KEEP_W)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mi_tdata   (meta_in_tdata),
    .mi_valid   (meta_in_valid),
    .mi_ready   (meta_in_ready),
    .din_valid  (din_valid),
    .din_ready  (din_ready),
    .fifo_full  (fifo_full),
    .beat_final (beat_final),
    .beat_bytes (beat_bytes),
    .wr_en      (wr_en),
    .len_mode   (len_mode),
    .rem_bytes  (rem_bytes),
    .mo_tdata   (meta_out_tdata),
    .mo_valid   (meta_out_valid),
    .mo_ready   (meta_out_ready),
    .rd_fire    (rd_en),
    .rd_last    (dout_tlast),
    .drain_en   (drain_en)
  );

  tpf_beat_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) fifo_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_entry),
    .rd_en   (rd_en),
    .rd_data (rd_entry),
    .count   (fifo_count),
    .full    (fifo_full),
    .empty   (fifo_empty)
  );

  assign dout_valid = drain_en && !fifo_empty;
  assign rd_en      = dout_valid && dout_ready;
  assign dout_tdata = rd_entry[DATA_W-1:0];
  assign dout_tkeep = rd_entry[DATA_W +: KEEP_W];
  assign dout_tlast = rd_entry[ENTRY_W-1];
endmodule

// File: rtl/tpf_tx_framer_chk.sv
module tpf_tx_framer_chk #(
  parameter int DATA_W = 64,
  localparam int KEEP_W = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              meta_in_valid,
  input logic              meta_in_ready,
  input logic              din_valid,
  input logic              din_ready,
  input logic [63:0]       meta_out_tdata,
  input logic              meta_out_valid,
  input logic              meta_out_ready,
  input logic [DATA_W-1:0] dout_tdata,
  input logic [KEEP_W-1:0] dout_tkeep,
  input logic              dout_tlast,
  input logic              dout_valid,
  input logic              dout_ready
);
  logic        pkt_open, hdr_done;
  logic [15:0] out_bytes, hdr_len;
  logic        mi_fire, mo_fire, do_fire, do_end;

  assign mi_fire = meta_in_valid && meta_in_ready;
  assign mo_fire = meta_out_valid && meta_out_ready;
  assign do_fire = dout_valid && dout_ready;
  assign do_end  = do_fire && dout_tlast;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_open  <= 1'b0;
      hdr_done  <= 1'b0;
      out_bytes <= '0;
      hdr_len   <= '0;
    end else begin
      if (mi_fire) pkt_open <= 1'b1;
      if (mo_fire) begin
        hdr_done <= 1'b1;
        hdr_len  <= meta_out_tdata[63:48];
      end
      if (do_fire) out_bytes <= do_end ? 16'd0 : out_bytes + 16'($countones(dout_tkeep));
      if (do_end) begin
        pkt_open <= 1'b0;
        hdr_done <= 1'b0;
      end
    end
  end

  assert_one_in_flight_R1: assert property (@(posedge clk) disable iff (!rst_n)
    meta_in_ready |-> !pkt_open);

  assert_data_after_meta_R2: assert property (@(posedge clk) disable iff (!rst_n)
    din_ready |-> pkt_open);

  // also covers R4/R5 byte accounting in length mode
  assert_len_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    do_end |-> (out_bytes + 16'($countones(dout_tkeep)) == hdr_len));

  assert_hdr_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> hdr_done);

  assert_meta_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (meta_out_valid && !meta_out_ready) |=> (meta_out_valid && $stable(meta_out_tdata)));

  assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready) |=>
      (dout_valid && $stable(dout_tdata) && $stable(dout_tkeep) && $stable(dout_tlast)));
endmodule

bind tpf_tx_framer tpf_tx_framer_chk #(.DATA_W(DATA_W)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .meta_in_valid  (meta_in_valid),
  .meta_in_ready  (meta_in_ready),
  .din_valid      (din_valid),
  .din_ready      (din_ready),
  .meta_out_tdata (meta_out_tdata),
  .meta_out_valid (meta_out_valid),
  .meta_out_ready (meta_out_ready),
  .dout_tdata     (dout_tdata),
  .dout_tkeep     (dout_tkeep),
  .dout_tlast     (dout_tlast),
  .dout_valid     (dout_valid),
  .dout_ready     (dout_ready)
);

// File: tb/tpf_tx_framer_tb.sv
module tpf_tx_framer_tb_top;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [63:0] meta_in_tdata;
  logic        meta_in_valid, meta_in_ready;
  logic [63:0] din_tdata;
  logic [7:0]  din_tkeep;
  logic        din_tlast, din_valid, din_ready;
  logic [63:0] meta_out_tdata;
  logic        meta_out_valid, meta_out_ready;
  logic [63:0] dout_tdata;
  logic [7:0]  dout_tkeep;
  logic        dout_tlast, dout_valid, dout_ready;

  int total = 0;
  int bad   = 0;

  logic [63:0] got_d[$];
  logic [7:0]  got_k[$];
  bit          got_l[$];

  tpf_tx_framer #(.DATA_W(64), .DEPTH(DEPTH)) dut_i (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_meta(input int len, input int pk);
    return {16'(len), 16'(2718 + pk), 8'(pk + 1), 16'(3000 - pk), 8'(pk ^ 3)};
  endfunction

  function automatic logic [63:0] dword(input int pk, input int b);
    return {32'(pk), 32'(b)} ^ 64'hA5C3_0F17_5A3C_F0E1;
  endfunction

  task automatic send_meta(input logic [63:0] m);
    meta_in_tdata = m; meta_in_valid = 1'b1; #1;
    while (!meta_in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    meta_in_valid = 1'b0;
  endtask

  task automatic push(input logic [63:0] d, input logic [7:0] k, input bit l);
    din_tdata = d; din_tkeep = k; din_tlast = l; din_valid = 1'b1; #1;
    while (!din_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    din_valid = 1'b0; din_tlast = 1'b0;
  endtask

  task automatic collect(input bit bp, output logic [63:0] meta);
    int guard;
    got_d.delete(); got_k.delete(); got_l.delete();
    meta = '0;
    guard = 0;
    forever begin
      meta_out_ready = bp ? guard[0] : 1'b1; #1;
      if (meta_out_valid && meta_out_ready) begin
        meta = meta_out_tdata; @(negedge clk); break;
      end
      @(negedge clk); guard++;
      if (guard > 200) break;
    end
    meta_out_ready = 1'b0;
    guard = 0;
    forever begin
      dout_ready = bp ? guard[0] : 1'b1; #1;
      if (dout_valid && dout_ready) begin
        got_d.push_back(dout_tdata); got_k.push_back(dout_tkeep); got_l.push_back(dout_tlast);
        if (dout_tlast) begin @(negedge clk); break; end
      end
      @(negedge clk); guard++;
      if (guard > 400) break;
    end
    dout_ready = 1'b0;
  endtask

  task automatic run_len(input int len, input int pk, input bit bp);
    int nb = (len + 7) / 8;
    logic [63:0] m = mk_meta(len, pk);
    logic [63:0] got_m;
    logic [7:0]  fk = (len % 8 == 0) ? 8'hFF : 8'((1 << (len % 8)) - 1);
    send_meta(m); #1;
    chk("R4 meta_out_valid next cycle", meta_out_valid, 1);
    chk("R1 meta_in_ready low in flight", meta_in_ready, 0);
    for (int b = 0; b < nb; b++) push(dword(pk, b), 8'h3C, (b == 0) && (nb > 1));
    #1;
    chk("R4 no beat past length", din_ready, 0);
    chk("R8 no data before meta taken", dout_valid, 0);
    collect(bp, got_m);
    chk("R3 R4 meta out word", got_m, m);
    chk("R4 beat count", got_d.size(), nb);
    if (got_d.size() == nb) begin
      for (int b = 0; b < nb; b++) begin
        chk("R9 data order", got_d[b], dword(pk, b));
        chk("R5 keep", got_k[b], (b == nb - 1) ? fk : 8'hFF);
        chk("R5 tlast placement", got_l[b], b == nb - 1);
      end
    end
    #1;
    chk("R1 meta_in_ready back", meta_in_ready, 1);
  endtask

  function automatic logic [7:0] kk(input int nb, input int b);
    return (b == nb - 1) ? (8'hFF >> (nb % 8)) : (8'hFF >> (b % 4));
  endfunction

  task automatic run_tlast(input int nb, input int pk, input bit bp, input bit trunc);
    logic [63:0] got_m;
    int sum = 0;
    send_meta(mk_meta(0, pk));
    for (int b = 0; b < nb; b++) begin
      sum += $countones(kk(nb, b));
      if (b == nb - 1) begin
        #1;
        chk("R6 meta held until tlast", meta_out_valid, 0);
      end
      push(dword(pk, b), kk(nb, b), !trunc && (b == nb - 1));
    end
    #1;
    chk("R6 meta valid after tlast", meta_out_valid, 1);
    if (trunc) chk("R7 input closed at depth", din_ready, 0);
    collect(bp, got_m);
    chk("R3 R6 meta out word", got_m, mk_meta(sum, pk));
    chk("R6 R7 beat count", got_d.size(), nb);
    if (got_d.size() == nb) begin
      for (int b = 0; b < nb; b++) begin
        chk("R9 data order", got_d[b], dword(pk, b));
        chk("R6 keep passthrough", got_k[b], kk(nb, b));
        chk("R6 R7 tlast placement", got_l[b], b == nb - 1);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R9 progress act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] gm;
    rst_n = 1'b0;
    meta_in_tdata = '0; meta_in_valid = 1'b0;
    din_tdata = '0; din_tkeep = '0; din_tlast = 1'b0; din_valid = 1'b0;
    meta_out_ready = 1'b0; dout_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 meta_in_ready", meta_in_ready, 1);
    chk("R10 din_ready", din_ready, 0);
    chk("R10 meta_out_valid", meta_out_valid, 0);
    chk("R10 dout_valid", dout_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: a beat offered before metadata is held off, then taken
    din_tdata = dword(100, 0); din_tkeep = 8'h0F; din_tlast = 1'b1; din_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R2 din_ready low without meta", din_ready, 0);
      chk("R8 dout_valid idle", dout_valid, 0);
      @(negedge clk);
    end
    send_meta(mk_meta(0, 100)); #1;
    chk("R2 din_ready after meta", din_ready, 1);
    @(negedge clk);
    din_valid = 1'b0; din_tlast = 1'b0;
    collect(1'b0, gm);
    chk("R2 R6 held beat meta", gm, mk_meta(4, 100));
    chk("R2 held beat count", got_d.size(), 1);
    if (got_d.size() == 1) chk("R2 held beat data", got_d[0], dword(100, 0));

    for (int len = 1; len <= 40; len++) run_len(len, len, len[0]);
    run_len(8 * DEPTH, 77, 1'b1);
    for (int nb = 1; nb <= 8; nb++) run_tlast(nb, 50 + nb, nb[0], 1'b0);
    run_tlast(DEPTH, 90, 1'b1, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule